// File: doc/BRIEF.md
# Output-Disable Request Input Detector

This block watches four active-low shutdown request inputs and keeps a sticky request flag for each one. A power-stage controller uses the OR of these flags to force its drive outputs to high impedance. Each input has its own detection mode. It can react to a falling edge, or to a low level that stays low across sixteen consecutive samples taken at one of three divided rates of the peripheral clock.

Software reaches the block through one 16-bit register. That register holds the four flags, an interrupt enable and four 2-bit mode fields. To clear a flag, software must first read it as 1 and then write 0 to it. The mode fields and the enable accept only the first write after reset. The block drives an interrupt line, which is gated by the enable, and an ungated high-impedance request.

Top module: `odr_detect`

## Requirements
- R1: After reset every register bit reads 0, and `irq` and `hiz_req` are both 0.
- R2: Register layout: flag of input i at bit 12+i (input 3 at bit 15); interrupt enable at bit 8; mode of input i at bits 2i+1:2i (input 3 at bits 7:6); bits 11:9 always read 0 and ignore writes.
- R3: Mode 00 selects falling-edge detection: a high-to-low transition on the synchronised input sets that input's flag.
- R4: Modes 01, 10 and 11 select low-level detection sampled at clock/8, clock/16 and clock/128. The flag sets after 16 consecutive low samples, and any high sample restarts the count.
- R5: A flag clears only on a write of 0 to its bit after a read that returned it as 1. Writing 1 has no effect. Any register write consumes the read history.
- R6: In level mode a flag cannot be cleared until a high level on that input has been sampled at the selected rate.
- R7: The mode fields and the interrupt enable take only the first register write after reset. Later writes leave them unchanged.
- R8: When a set condition and a valid clear meet in the same cycle, the flag stays set.
- R9: `irq` is the OR of all flags gated by the enable. `hiz_req` is the OR of all flags regardless of the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 4 | Active-low request inputs, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register contents |
| irq | output | 1 | Interrupt request |
| hiz_req | output | 1 | Combined high-impedance request |

## Verification
Two events can fall in the same cycle: a new detection on an input and a valid clear of that input's flag, meaning a write of 0 after a read of 1. The bench arms the clear by reading the flag. It then drives a second falling edge on the input, timed so that the write strobe lands in the one cycle in which the synchronised edge is presented to the flag. The flag must read back as set. A further write of 0 without a fresh read must also leave it set, which shows that the colliding write consumed the read history.

// File: rtl/odr_pkg.sv
package odr_pkg;
    localparam int NPIN     = 4;
    localparam int MODE_W   = 2;
    localparam int REG_W    = 16;
    localparam int FLAG_LSB = 12;
    localparam int EN_BIT   = 8;

    typedef enum logic [1:0] {
        DET_FALL  = 2'b00,
        DET_LVL_A = 2'b01,
        DET_LVL_B = 2'b10,
        DET_LVL_C = 2'b11
    } det_mode_e;
endpackage

// File: rtl/odr_prescale.sv
module odr_prescale #(
    parameter int DIV_A = 8,
    parameter int DIV_B = 16,
    parameter int DIV_C = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] tick
);
    localparam int CW = $clog2(DIV_C);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // one strobe per divided rate; divisors are powers of two
    for (genvar k = 0; k < 3; k++) begin : g_tick
        localparam int DV = (k == 0) ? DIV_A : (k == 1) ? DIV_B : DIV_C;
        assign tick[k] = (cnt_q & CW'(DV - 1)) == CW'(DV - 1);
    end

    // slowest strobe always coincides with the faster ones
    assert_tick_nest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick[2] |-> (tick[1] && tick[0]));
endmodule

// File: rtl/odr_pin_det.sv
module odr_pin_det
    import odr_pkg::*;
#(
    parameter int LOW_CNT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_n,
    input  logic [1:0] mode,
    input  logic [2:0] tick,
    output logic       set_cond
);
    localparam int CW = $clog2(LOW_CNT + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          prev;
        logic [CW-1:0] cnt;
    } det_st_t;

    det_st_t st_d, st_q;
    logic    sel_tick;

    always_comb begin
        unique case (det_mode_e'(mode))
            DET_LVL_A: sel_tick = tick[0];
            DET_LVL_B: sel_tick = tick[1];
            DET_LVL_C: sel_tick = tick[2];
            default:   sel_tick = 1'b0;
        endcase

        st_d      = st_q;
        st_d.s1   = req_n;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        if (det_mode_e'(mode) == DET_FALL) begin
            st_d.cnt = '0;
        end else if (sel_tick) begin
            if (st_q.s2)                         st_d.cnt = '0;
            else if (st_q.cnt != CW'(LOW_CNT))   st_d.cnt = st_q.cnt + CW'(1);
        end

        if (det_mode_e'(mode) == DET_FALL) set_cond = st_q.prev & ~st_q.s2;
        else                               set_cond = (st_q.cnt == CW'(LOW_CNT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1   <= 1'b1;
            st_q.s2   <= 1'b1;
            st_q.prev <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // level count only moves on a sample strobe of the chosen rate
    assert_cnt_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != $past(st_q.cnt)) |-> ($past(sel_tick) || $past(det_mode_e'(mode) == DET_FALL)));
    // a full low count is left only through a high sample (or mode fallback)
    assert_lvl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.cnt == CW'(LOW_CNT)) && (st_q.cnt != CW'(LOW_CNT)))
            |-> ($past(st_q.s2) || $past(det_mode_e'(mode) == DET_FALL)));
endmodule

// File: rtl/odr_detect.sv
module odr_detect
    import odr_pkg::*;
#(
    parameter int DIV_A   = 8,
    parameter int DIV_B   = 16,
    parameter int DIV_C   = 128,
    parameter int LOW_CNT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIN-1:0]  req_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq,
    output logic             hiz_req
);
    localparam int MODES_W = NPIN * MODE_W;

    typedef struct packed {
        logic [NPIN-1:0]    flag;
        logic [NPIN-1:0]    armed;
        logic [MODES_W-1:0] mode;
        logic               en;
        logic               lock;
    } reg_st_t;

    reg_st_t         st_d, st_q;
    logic [2:0]      tick;
    logic [NPIN-1:0] set_vec;
    logic [NPIN-1:0] clr_vec;
    logic            unused_rsvd;

    assign unused_rsvd = ^reg_wdata[FLAG_LSB-1:EN_BIT+1];

    odr_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        odr_pin_det #(.LOW_CNT(LOW_CNT)) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_n   (req_n[i]),
            .mode    (st_q.mode[MODE_W*i +: MODE_W]),
            .tick    (tick),
            .set_cond(set_vec[i])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NPIN; i++) begin
            clr_vec[i]    = reg_wr & ~reg_wdata[FLAG_LSB+i] & st_q.armed[i];
            st_d.flag[i]  = set_vec[i] | (st_q.flag[i] & ~clr_vec[i]);
            if (reg_wr)                          st_d.armed[i] = 1'b0;
            else if (reg_rd && st_q.flag[i])     st_d.armed[i] = 1'b1;
        end
        if (reg_wr && !st_q.lock) begin
            st_d.mode = reg_wdata[MODES_W-1:0];
            st_d.en   = reg_wdata[EN_BIT];
            st_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = {st_q.flag, 3'b000, st_q.en, st_q.mode};
    assign hiz_req   = |st_q.flag;
    assign irq       = st_q.en & (|st_q.flag);

    for (genvar i = 0; i < NPIN; i++) begin : g_chk
        // clearing is only ever the result of an armed write of 0
        assert_clear_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st_q.flag[i]) |-> ($past(reg_wr) && !$past(reg_wdata[FLAG_LSB+i])
                                     && $past(st_q.armed[i])));
        // detection beats a simultaneous clear
        assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> st_q.flag[i]);
    end

    assert_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> ($stable(st_q.mode) && $stable(st_q.en)));
    assert_irq_implies_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> hiz_req);
endmodule

// File: tb/odr_detect_tb.sv
module odr_detect_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  req_n;
    logic        reg_wr, reg_rd;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        irq, hiz_req;

    int total = 0;
    int bad   = 0;
    logic [15:0] rd_val;

    always #5 clk = ~clk;

    odr_detect dut_i (
        .clk(clk), .rst_n(rst_n), .req_n(req_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .hiz_req(hiz_req)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_n = 4'hF; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    task automatic rd_reg(output logic [15:0] v);
        @(negedge clk);
        reg_rd = 1'b1;
        v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 rdata", reg_rdata, 16'h0000);
        chk("R1 irq", {15'b0, irq}, 16'h0);
        chk("R1 hiz", {15'b0, hiz_req}, 16'h0);
    endtask

    task automatic t_layout_lock();
        do_reset();
        wr_reg(16'hFFFF);
        chk("R2 layout/reserved", reg_rdata, 16'h01FF);
        wr_reg(16'h0000);
        chk("R7 write once", reg_rdata, 16'h01FF);
        chk("R2 no flags from write", {15'b0, hiz_req}, 16'h0);
    endtask

    task automatic t_edge_clear();
        do_reset();
        wr_reg(16'h0100);
        @(negedge clk); req_n[2] = 1'b0;
        wait_cyc(1);
        chk("R3 sync delay", reg_rdata, 16'h0100);
        wait_cyc(3);
        chk("R3 edge sets bit14 (R2)", reg_rdata, 16'h4100);
        chk("R9 irq on", {15'b0, irq}, 16'h1);
        chk("R9 hiz on", {15'b0, hiz_req}, 16'h1);
        wr_reg(16'h0000);
        chk("R5 no clear without read", reg_rdata, 16'h4100);
        rd_reg(rd_val);
        chk("R5 read value", rd_val, 16'h4100);
        wr_reg(16'h4000);
        chk("R5 write 1 no effect", reg_rdata, 16'h4100);
        rd_reg(rd_val);
        wr_reg(16'h0000);
        chk("R5 read then write 0 clears", reg_rdata, 16'h0100);
        chk("R9 irq off", {15'b0, irq}, 16'h0);
    endtask

    task automatic t_irq_gate();
        do_reset();
        wr_reg(16'h0000);
        @(negedge clk); req_n[0] = 1'b0;
        wait_cyc(5);
        chk("R9 flag0 set", reg_rdata, 16'h1000);
        chk("R9 hiz ungated", {15'b0, hiz_req}, 16'h1);
        chk("R9 irq gated", {15'b0, irq}, 16'h0);
    endtask

    task automatic t_level_rate(input logic [1:0] m, input int early, input int late, input string tag);
        do_reset();
        wr_reg(16'h0100 | (16'(m) << 2));
        @(negedge clk); req_n[1] = 1'b0;
        wait_cyc(early);
        chk({tag, " not yet"}, {15'b0, reg_rdata[13]}, 16'h0);
        wait_cyc(late - early);
        chk({tag, " set"}, {15'b0, reg_rdata[13]}, 16'h1);
    endtask

    task automatic t_level_restart();
        do_reset();
        wr_reg(16'h0104);
        @(negedge clk); req_n[1] = 1'b0;
        wait_cyc(80);
        req_n[1] = 1'b1;
        wait_cyc(30);
        req_n[1] = 1'b0;
        wait_cyc(80);
        chk("R4 restart after high", {15'b0, reg_rdata[13]}, 16'h0);
        wait_cyc(80);
        chk("R4 set after restart", {15'b0, reg_rdata[13]}, 16'h1);
    endtask

    task automatic t_level_clear();
        do_reset();
        wr_reg(16'h0140);
        @(negedge clk); req_n[3] = 1'b0;
        wait_cyc(200);
        chk("R6 level set bit15", reg_rdata, 16'h8140);
        req_n[3] = 1'b1;
        rd_reg(rd_val);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 16'h0000;
        @(negedge clk); reg_wr = 1'b0;
        chk("R6 no clear before high sample", reg_rdata, 16'h8140);
        wait_cyc(20);
        rd_reg(rd_val);
        wr_reg(16'h0000);
        chk("R6 clear after high sample", reg_rdata, 16'h0140);
    endtask

    task automatic t_collision();
        do_reset();
        wr_reg(16'h0100);
        @(negedge clk); req_n[0] = 1'b0;
        wait_cyc(5);
        req_n[0] = 1'b1;
        wait_cyc(5);
        rd_reg(rd_val);
        chk("R8 armed read", rd_val, 16'h1100);
        req_n[0] = 1'b0;
        wait_cyc(2);
        reg_wr = 1'b1; reg_wdata = 16'h0000;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R8 set wins over clear", reg_rdata, 16'h1100);
        wr_reg(16'h0000);
        chk("R5 history consumed by write", reg_rdata, 16'h1100);
        rd_reg(rd_val);
        wr_reg(16'h0000);
        chk("R5 clear after fresh read", reg_rdata, 16'h0100);
    endtask

    initial begin
        rst_n = 1'b0; req_n = 4'hF; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
        t_reset();
        t_layout_lock();
        t_edge_clear();
        t_irq_gate();
        t_level_rate(2'b01, 100, 160, "R4 div8");
        t_level_rate(2'b10, 220, 300, "R4 div16");
        t_level_rate(2'b11, 1900, 2250, "R4 div128");
        t_level_restart();
        t_level_clear();
        t_collision();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule